// File: doc/BRIEF.md
# Recursive Doubling Barrier Engine

Each process in a group of `NUM_RANKS` participants carries one of these engines. When the local start strobe is seen, the engine runs the signalling schedule of a recursive doubling barrier. It emits one token at a time, each addressed to a peer index. It collects incoming tokens, and each incoming token is identified by its source position on a per-source input vector. When the last token of its schedule has been exchanged, it raises a one-cycle completion pulse. No rank can complete before every rank in the group has started.

The group is split into a core of `N` ranks, where `N` is the largest power of two not above `NUM_RANKS`, and a set of surplus ranks numbered `N` and up. Each surplus rank `r` is folded onto core rank `r-N`. The surplus rank first tells its partner that it has arrived. The partner then joins the `log2(N)` exchange steps of the core, in which the step-`l` peer is the own rank XOR `2^l`. When the core steps are done, the partner releases the surplus rank.

The engine is used with an external token transport. That transport may deliver tokens with arbitrary delay and in any order across steps. The engine holds tokens that arrive early until their step comes round.

Top module: `rdb_barrier_engine`

## Requirements
- R1: With L = floor(log2(NUM_RANKS)) and N = 2^L, a core rank (rank < N) sends exactly L step tokens per barrier, plus one release token if it has a surplus partner. A surplus rank sends exactly one token. For six ranks the whole group emits 12 tokens per barrier.
- R2: The k-th step token of core rank r (k = 0..L-1) is addressed to r XOR 2^k, in ascending k order. No token is ever addressed to the sender itself or to an index of NUM_RANKS or above.
- R3: A core rank issues its step-k token (k ≥ 1), and its release token, only after the token from its step-(k-1) peer has arrived. Between two tokens of one rank there is at least one idle cycle.
- R4: A surplus rank r first sends one token to r-N. It completes only after a token from r-N has arrived.
- R5: A core rank r with r+N < NUM_RANKS sends nothing until the token from rank r+N has arrived.
- R6: After its last core step, a core rank with a surplus partner sends one release token to r+N, in the same cycle as its completion pulse.
- R7: A token that arrives before its step is reached is held per source bit of `tok_in`. It is consumed when that step is reached, so reordering across steps cannot deadlock the barrier.
- R8: `done` is high for exactly one cycle per barrier. No rank raises it before every rank of the group has been started.
- R9: A `start` pulse while a barrier is in progress is ignored: that rank still completes exactly once and sends no extra token.
- R10: With NUM_RANKS = 1, `done` is high in the cycle after `start` and no token is ever sent.
- R11: During and directly after reset, `tok_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| my_rank | input | RANK_W | Own rank index, held constant |
| start | input | 1 | Begin a barrier when idle |
| tok_in | input | NUM_RANKS | Bit s is a one-cycle token from rank s |
| tok_valid | output | 1 | Registered: a token leaves this cycle |
| tok_dest | output | RANK_W | Registered destination index of the token |
| done | output | 1 | Registered one-cycle completion pulse |

## Verification
All outputs are registered, so `tok_valid`, `tok_dest` and `done` change on a rising edge and are sampled at the following falling edge.

- With one rank, `done` is due exactly one cycle after the edge that captures `start`.
- A token that arrives on `tok_in` is latched on the next edge and consumed on the edge after that. The next outgoing token then appears one edge later, so three edges after arrival.

The bench's token fabric samples the senders at each falling edge and schedules delivery at least one cycle later. It checks each token's destination and order against the schedule of R1 and R2 at the moment the token appears. It also checks that the token the schedule waits on has already been delivered at that moment. Completion counts and total token counts are compared only after a drain window, so late deliveries are included.

// File: rtl/rdb_pkg.sv
package rdb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE_TX,
    ST_PRE_RX,
    ST_STEP_TX,
    ST_STEP_RX,
    ST_POST_TX
  } rdb_state_e;

  function automatic int floor_log2(input int v);
    int r;
    r = 0;
    for (int i = 0; i < 30; i++)
      if ((1 << (i + 1)) <= v) r = i + 1;
    return r;
  endfunction

  function automatic int bits_for(input int v);
    return (v <= 1) ? 1 : $clog2(v);
  endfunction

endpackage

// File: rtl/rdb_peer_map.sv
module rdb_peer_map #(
  parameter int NUM_RANKS = 6,
  parameter int RANK_W    = 3,
  parameter int STEP_W    = 1,
  parameter int CORE_N    = 4
) (
  input  logic [RANK_W-1:0] my_rank,
  input  logic [STEP_W-1:0] step,
  output logic [RANK_W-1:0] step_peer,
  output logic [RANK_W-1:0] fold_peer,
  output logic              is_extra,
  output logic              has_fold
);
  localparam logic [RANK_W-1:0] CORE_R = RANK_W'(CORE_N);

  always_comb begin
    is_extra  = int'(my_rank) >= CORE_N;
    has_fold  = !is_extra && ((int'(my_rank) + CORE_N) < NUM_RANKS);
    fold_peer = is_extra ? (my_rank - CORE_R) : (my_rank + CORE_R);
    step_peer = my_rank ^ RANK_W'(32'd1 << step);
  end
endmodule

// File: rtl/rdb_token_latch.sv
module rdb_token_latch #(
  parameter int NUM_RANKS = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_RANKS-1:0] arrive,
  input  logic [NUM_RANKS-1:0] consume,
  output logic [NUM_RANKS-1:0] pending
);
  always_ff @(posedge clk) begin
    if (rst) pending <= '0;
    else     pending <= (pending & ~consume) | arrive;
  end
endmodule

// File: rtl/rdb_sequencer.sv
module rdb_sequencer
  import rdb_pkg::*;
#(
  parameter int NUM_RANKS = 6,
  parameter int RANK_W    = 3,
  parameter int STEP_W    = 1,
  parameter int LOG_N     = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [RANK_W-1:0]    step_peer,
  input  logic [RANK_W-1:0]    fold_peer,
  input  logic                 is_extra,
  input  logic                 has_fold,
  input  logic [NUM_RANKS-1:0] pending,
  output logic [STEP_W-1:0]    step,
  output logic [NUM_RANKS-1:0] consume,
  output logic                 tok_valid,
  output logic [RANK_W-1:0]    tok_dest,
  output logic                 done
);
  rdb_state_e        state;
  logic [RANK_W-1:0] peer_sel;
  logic              peer_hit;

  always_comb begin
    peer_sel = (state == ST_STEP_RX) ? step_peer : fold_peer;
    peer_hit = ((state == ST_PRE_RX) || (state == ST_STEP_RX)) && pending[peer_sel];
    consume  = '0;
    if (peer_hit) consume[peer_sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      step      <= '0;
      tok_valid <= 1'b0;
      tok_dest  <= '0;
      done      <= 1'b0;
    end else begin
      tok_valid <= 1'b0;
      done      <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          step <= '0;
          if (is_extra)        state <= ST_PRE_TX;
          else if (has_fold)   state <= ST_PRE_RX;
          else if (LOG_N == 0) done  <= 1'b1;
          else                 state <= ST_STEP_TX;
        end
        ST_PRE_TX: begin
          tok_valid <= 1'b1;
          tok_dest  <= fold_peer;
          state     <= ST_PRE_RX;
        end
        ST_PRE_RX: if (peer_hit) begin
          if (is_extra) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            state <= ST_STEP_TX;
          end
        end
        ST_STEP_TX: begin
          tok_valid <= 1'b1;
          tok_dest  <= step_peer;
          state     <= ST_STEP_RX;
        end
        ST_STEP_RX: if (peer_hit) begin
          if (int'(step) == LOG_N - 1) begin
            state <= has_fold ? ST_POST_TX : ST_IDLE;
            done  <= !has_fold;
          end else begin
            step  <= step + 1'b1;
            state <= ST_STEP_TX;
          end
        end
        ST_POST_TX: begin
          tok_valid <= 1'b1;
          tok_dest  <= fold_peer;
          done      <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rdb_barrier_engine.sv
module rdb_barrier_engine #(
  parameter int NUM_RANKS = 6,
  parameter int RANK_W    = rdb_pkg::bits_for(NUM_RANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [RANK_W-1:0]    my_rank,
  input  logic                 start,
  input  logic [NUM_RANKS-1:0] tok_in,
  output logic                 tok_valid,
  output logic [RANK_W-1:0]    tok_dest,
  output logic                 done
);
  localparam int LOG_N  = rdb_pkg::floor_log2(NUM_RANKS);
  localparam int CORE_N = 1 << LOG_N;
  localparam int STEP_W = rdb_pkg::bits_for(LOG_N);

  logic [STEP_W-1:0]    step;
  logic [RANK_W-1:0]    step_peer, fold_peer;
  logic                 is_extra, has_fold;
  logic [NUM_RANKS-1:0] pending, consume;

  rdb_peer_map #(
    .NUM_RANKS(NUM_RANKS), .RANK_W(RANK_W), .STEP_W(STEP_W), .CORE_N(CORE_N)
  ) peer_i (
    .my_rank(my_rank), .step(step), .step_peer(step_peer),
    .fold_peer(fold_peer), .is_extra(is_extra), .has_fold(has_fold)
  );

  rdb_token_latch #(.NUM_RANKS(NUM_RANKS)) latch_i (
    .clk(clk), .rst(rst), .arrive(tok_in), .consume(consume), .pending(pending)
  );

  rdb_sequencer #(
    .NUM_RANKS(NUM_RANKS), .RANK_W(RANK_W), .STEP_W(STEP_W), .LOG_N(LOG_N)
  ) seq_i (
    .clk(clk), .rst(rst), .start(start), .step_peer(step_peer),
    .fold_peer(fold_peer), .is_extra(is_extra), .has_fold(has_fold),
    .pending(pending), .step(step), .consume(consume),
    .tok_valid(tok_valid), .tok_dest(tok_dest), .done(done)
  );
endmodule

// File: rtl/rdb_barrier_checker.sv
module rdb_barrier_checker #(
  parameter int NUM_RANKS = 6,
  parameter int RANK_W    = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [RANK_W-1:0] my_rank,
  input logic              tok_valid,
  input logic [RANK_W-1:0] tok_dest,
  input logic              done
);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_token_gap_R3: assert property (@(posedge clk) disable iff (rst)
    tok_valid |=> !tok_valid);

  assert_dest_legal_R2: assert property (@(posedge clk) disable iff (rst)
    tok_valid |-> ((int'(tok_dest) < NUM_RANKS) && (tok_dest != my_rank)));

  assert_solo_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    tok_valid |-> (NUM_RANKS > 1));

  assert_solo_done_R10: assert property (@(posedge clk) disable iff (rst)
    (start && (NUM_RANKS == 1)) |=> done);

  assert_reset_quiet_R11: assert property (@(posedge clk)
    rst |=> (!tok_valid && !done));
endmodule

bind rdb_barrier_engine rdb_barrier_checker #(
  .NUM_RANKS(NUM_RANKS), .RANK_W(RANK_W)
) chk_i (
  .clk(clk), .rst(rst), .start(start), .my_rank(my_rank),
  .tok_valid(tok_valid), .tok_dest(tok_dest), .done(done)
);

// File: tb/rdb_barrier_engine_tb_top.sv
module rdb_barrier_engine_tb_top;
  localparam int M6 = 6, RW6 = 3, N6 = 4, L6 = 2;
  localparam int VEC_N = 4;
  localparam bit [31:0] VEC_SEED [VEC_N] = '{32'h1234, 32'hBEEF, 32'h0C0FFEE, 32'h5A5A};
  localparam int VEC_DLY  [VEC_N] = '{1, 3, 7, 12};
  localparam int VEC_SKEW [VEC_N] = '{0, 4, 9, 20};
  localparam int VEC_TOK  [VEC_N] = '{12, 12, 12, 12};

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic           start6 [M6];
  logic [M6-1:0]  arr6   [M6];
  logic           tok_v6 [M6];
  logic [RW6-1:0] dest6  [M6];
  logic           done6  [M6];
  logic start1 = 1'b0;
  logic [0:0] arr1 = 1'b0;
  logic tok_v1, done1;
  logic [0:0] dest1;

  for (genvar r = 0; r < M6; r++) begin : g_rank
    rdb_barrier_engine #(.NUM_RANKS(M6)) dut_i (
      .clk(clk), .rst(rst), .my_rank(RW6'(r)), .start(start6[r]),
      .tok_in(arr6[r]), .tok_valid(tok_v6[r]), .tok_dest(dest6[r]), .done(done6[r]));
  end

  rdb_barrier_engine #(.NUM_RANKS(1)) solo_i (
    .clk(clk), .rst(rst), .my_rank(1'b0), .start(start1), .tok_in(arr1),
    .tok_valid(tok_v1), .tok_dest(dest1), .done(done1));

  int sent_cnt [M6];
  int done_cnt [M6];
  bit delivered [M6][M6];
  bit started [M6];
  int dly [M6][M6];
  bit [31:0] lfsr = 32'h1;
  int maxdly = 1;
  bit hold_on = 1'b0;
  int hold_s = 0, hold_d = 0;
  int solo_tokens = 0;
  int checks = 0, fails = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function int next_rand();
    lfsr = lfsr * 32'd1103515245 + 32'd12345;
    return int'(lfsr[30:16]);
  endfunction

  function automatic int exp_len(input int r);
    if (r >= N6) return 1;
    return L6 + ((r + N6 < M6) ? 1 : 0);
  endfunction

  function automatic int exp_dest(input int r, input int k);
    if (r >= N6) return r - N6;
    if (k < L6) return r ^ (1 << k);
    return r + N6;
  endfunction

  function automatic int req_src(input int r, input int k);
    if (r >= N6) return -1;
    if (k == 0) return (r + N6 < M6) ? r + N6 : -1;
    return r ^ (1 << (k - 1));
  endfunction

  // token fabric and monitors
  always @(negedge clk) begin
    for (int d = 0; d < M6; d++) arr6[d] = '0;
    if (tok_v1) solo_tokens++;
    if (!rst) begin
      for (int s = 0; s < M6; s++)
        for (int d = 0; d < M6; d++)
          if (dly[s][d] == 1 && !(hold_on && s == hold_s && d == hold_d)) begin
            arr6[d][s] = 1'b1;
            delivered[d][s] = 1'b1;
            dly[s][d] = 0;
          end else if (dly[s][d] > 1) dly[s][d]--;
      for (int s = 0; s < M6; s++)
        if (tok_v6[s]) begin
          automatic int k = sent_cnt[s];
          automatic int dd = int'(dest6[s]);
          automatic int rq = req_src(s, k);
          check(k < exp_len(s), "R1", "token count per rank", k + 1, exp_len(s));
          check(dd == exp_dest(s, k), "R2", "token destination", dd, exp_dest(s, k));
          if (rq >= 0)
            check(delivered[s][rq], (k == 0) ? "R5" : "R3",
                  "awaited token present before send", 0, 1);
          if (dd < M6) dly[s][dd] = 1 + (next_rand() % maxdly);
          sent_cnt[s]++;
        end
      for (int r = 0; r < M6; r++)
        if (done6[r]) begin
          automatic int ns = 0;
          for (int q = 0; q < M6; q++) ns += started[q] ? 1 : 0;
          done_cnt[r]++;
          check(ns == M6, "R8", "all ranks started before done", ns, M6);
          check(sent_cnt[r] == exp_len(r), "R6", "tokens sent at done", sent_cnt[r], exp_len(r));
          if (r >= N6) check(delivered[r][r - N6], "R4", "release seen before done", 0, 1);
        end
    end
  end

  task automatic summary_and_end();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary_and_end();
    end
  end

  task automatic clear_state();
    for (int r = 0; r < M6; r++) begin
      sent_cnt[r] = 0;
      done_cnt[r] = 0;
      started[r] = 1'b0;
      start6[r] = 1'b0;
      for (int q = 0; q < M6; q++) begin
        delivered[r][q] = 1'b0;
        dly[r][q] = 0;
      end
    end
    hold_on = 1'b0;
  endtask

  task automatic wait_all_done(input string req);
    bit all;
    all = 1'b0;
    for (int t = 0; t < 3000 && !all; t++) begin
      all = 1'b1;
      for (int r = 0; r < M6; r++) if (done_cnt[r] == 0) all = 1'b0;
      if (!all) @(negedge clk);
    end
    check(all, req, "every rank completed", all, 1);
    repeat (30) @(negedge clk);
  endtask

  task automatic check_once_each(input string req, input int exp_tok);
    automatic int tot = 0;
    for (int r = 0; r < M6; r++) begin
      check(done_cnt[r] == 1, req, "done pulses per rank", done_cnt[r], 1);
      tot += sent_cnt[r];
    end
    check(tot == exp_tok, "R1", "total tokens per barrier", tot, exp_tok);
  endtask

  initial begin
    for (int r = 0; r < M6; r++) start6[r] = 1'b0;
    clear_state();
    repeat (3) @(negedge clk);
    for (int r = 0; r < M6; r++)
      check(!tok_v6[r] && !done6[r], "R11", "quiet in reset", int'(tok_v6[r]), 0);
    check(!done1 && !tok_v1, "R11", "single rank quiet in reset", int'(done1), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    for (int r = 0; r < M6; r++)
      check(!tok_v6[r] && !done6[r], "R11", "quiet after reset", int'(done6[r]), 0);

    // vector table: seed, delay bound, start skew, expected tokens
    for (int i = 0; i < VEC_N; i++) begin
      automatic int sk [M6];
      clear_state();
      lfsr = VEC_SEED[i];
      maxdly = VEC_DLY[i];
      for (int r = 0; r < M6; r++) sk[r] = next_rand() % (VEC_SKEW[i] + 1);
      for (int t = 0; t <= VEC_SKEW[i]; t++) begin
        for (int r = 0; r < M6; r++) begin
          start6[r] = (sk[r] == t);
          if (sk[r] == t) started[r] = 1'b1;
        end
        @(negedge clk);
      end
      for (int r = 0; r < M6; r++) start6[r] = 1'b0;
      wait_all_done("R8");
      check_once_each("R8", VEC_TOK[i]);
    end

    // R5 / R9: rank 4 late, rank 0 restarted while waiting
    clear_state();
    maxdly = 2;
    for (int r = 0; r < M6; r++) if (r != 4) begin start6[r] = 1'b1; started[r] = 1'b1; end
    @(negedge clk);
    for (int r = 0; r < M6; r++) start6[r] = 1'b0;
    repeat (25) @(negedge clk);
    check(sent_cnt[0] == 0, "R5", "rank 0 silent before partner token", sent_cnt[0], 0);
    check(done_cnt[0] + done_cnt[5] == 0, "R8", "no done before last start", done_cnt[0], 0);
    start6[0] = 1'b1;
    @(negedge clk);
    start6[0] = 1'b0;
    repeat (5) @(negedge clk);
    check(sent_cnt[0] == 0, "R9", "restart sent nothing", sent_cnt[0], 0);
    start6[4] = 1'b1;
    started[4] = 1'b1;
    @(negedge clk);
    start6[4] = 1'b0;
    wait_all_done("R9");
    check_once_each("R9", 12);

    // R3 / R7: step-0 token from rank 1 to rank 0 held back
    clear_state();
    maxdly = 3;
    hold_on = 1'b1;
    hold_s = 1;
    hold_d = 0;
    for (int r = 0; r < M6; r++) begin start6[r] = 1'b1; started[r] = 1'b1; end
    @(negedge clk);
    for (int r = 0; r < M6; r++) start6[r] = 1'b0;
    repeat (40) @(negedge clk);
    check(sent_cnt[0] == 1, "R3", "rank 0 stalled after step 0", sent_cnt[0], 1);
    check(delivered[0][2], "R7", "step-1 token arrived early", 0, 1);
    check(done_cnt[0] == 0, "R3", "rank 0 not done while held", done_cnt[0], 0);
    hold_on = 1'b0;
    wait_all_done("R7");
    check_once_each("R7", 12);

    // R10: single rank
    start1 = 1'b1;
    @(negedge clk);
    start1 = 1'b0;
    check(done1 == 1'b1, "R10", "single rank done next cycle", int'(done1), 1);
    @(negedge clk);
    check(done1 == 1'b0, "R8", "single rank done is a pulse", int'(done1), 0);
    repeat (3) @(negedge clk);
    check(solo_tokens == 0, "R10", "single rank sends no token", solo_tokens, 0);

    summary_and_end();
  end
endmodule